// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the slave side of a 4096-byte serial EEPROM that a host reaches over SPI. A fast system clock samples the four serial pins. A state machine takes in an opcode, a 16-bit byte address and data, all MSB first. It streams array bytes or the status byte back on the serial output, and it gathers up to one page of write data in a buffer. When chip select rises after a write, a timed write cycle commits the buffer to a synthesizable register array. The cycle length is a parameter counted in system clocks. While the cycle runs, only status reads get an answer.

Two protect bits in the status byte keep the top quarter, the top half or all of the array from being written. A lock-enable bit and an active-low write-protect pin together freeze those settings. The block does nothing until chip select has made one high-to-low transition after reset.

Serial state machine states: `ST_IDLE` (deselected or not yet armed), `ST_OPC` (shifting the opcode), `ST_ADDR` (two address bytes), `ST_RDATA` (array read stream), `ST_WDATA` (page buffer fill), `ST_SROUT` (status read stream), `ST_SRIN` (status byte in) and `ST_SKIP` (ignore until deselect). The transitions are as follows. Any state goes to `ST_IDLE` when chip select is high. A chip-select fall goes to `ST_OPC`. From `ST_OPC`, the read opcode goes to `ST_ADDR`. The write opcode goes to `ST_ADDR` only if the write-enable latch is set, and the status-write opcode goes to `ST_SRIN` on the same condition. The status-read opcode goes to `ST_SROUT`. All other opcodes, and every opcode except status read during a write cycle, go to `ST_SKIP`. After its second byte, `ST_ADDR` goes to `ST_RDATA` or `ST_WDATA`. After its one byte, `ST_SRIN` goes to `ST_SKIP`. The write engine is a flag with two states, idle and programming.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, all pin activity is ignored and the output enable stays low until chip select has fallen once.
- R2: `miso_en` is high only while chip select is low and a data byte of an array read or status read is being sent. It is low during opcode and address bytes and whenever the device is deselected.
- R3: SPI modes 0 and 3 both work. Input is taken on the rising clock and output changes on the falling clock. All fields are MSB first.
- R4: The status read opcode 0x05 repeats the status byte until deselect. Bit 0 is write-in-progress, bit 1 is write-enable, bits 3:2 are protect level, bit 7 is lock-enable, and the other bits read 0.
- R5: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R6: Write opcode 0x02 and status write opcode 0x01 are ignored when the write-enable latch is clear.
- R7: A page write takes up to 32 bytes. The address wraps within the 32-byte page, and a later byte to the same location replaces an earlier one.
- R8: Read opcode 0x03 auto-increments and wraps from address 0xFFF to 0x000. Address bits above bit 11 are ignored.
- R9: When chip select rises after a write that holds data, or after an accepted status write, write-in-progress is set for WR_CYCLES clocks. The write-enable latch clears when the cycle ends.
- R10: While a write cycle is in progress, only the status read is answered. Reads, enable and disable commands, and writes have no effect.
- R11: The protect level decides which locations a write leaves unchanged: 0 protects none, 1 protects 0xC00 to 0xFFF, 2 protects 0x800 to 0xFFF, and 3 protects the whole array.
- R12: When `wp_n` is low and lock-enable is 1, a status write changes neither the protect level nor lock-enable.
- R13: An unknown opcode makes the device ignore the rest of that selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-protect pin |
| miso | output | 1 | Serial data out |
| miso_en | output | 1 | Drive enable for `miso`; low means high impedance |

## Verification
A wrong opcode or bit-count state shows on the very next byte as a wrong `miso_en` level or a misread status byte. A corrupted page pointer or protect decode stays hidden until the array is read back after the write cycle. For that reason every write is followed by a read-back of the affected range and its neighbours. A stuck write-in-progress or write-enable bit shows in the first status read after the cycle time. A busy guard that leaks shows at once as an output enable during a read issued in mid-cycle.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_SROUT, ST_SRIN, ST_SKIP
    } spi_state_t;

    localparam logic [7:0] CMD_WEN   = 8'h06;
    localparam logic [7:0] CMD_WDIS  = 8'h04;
    localparam logic [7:0] CMD_RSTAT = 8'h05;
    localparam logic [7:0] CMD_WSTAT = 8'h01;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h02;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
    parameter int                 WIDTH = 4,
    parameter logic [WIDTH-1:0]   INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= INIT[i];
                s2 <= INIT[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [7:0] arr [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) arr[i] <= 8'hFF;
        end else if (we) begin
            arr[waddr] <= wdata;
        end
    end

    assign rdata = arr[raddr];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic miso,
    output logic miso_en
);
    import spi_ee_pkg::*;

    localparam int PAGE  = 1 << PAGE_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    // synchronised pins: {wp, cs, sck, si}; cs resets low so a pin held low from reset never arms
    logic [3:0] pins_s;
    logic wp_s, cs_s, sck_s, si_s;
    spi_ee_sync #(.WIDTH(4), .INIT(4'b1000)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({wp_n, cs_n, sck, mosi}), .q(pins_s)
    );
    assign {wp_s, cs_s, sck_s, si_s} = pins_s;

    spi_state_t state, nxt;
    logic sck_q, cs_q, armed;
    logic [2:0] bcnt;
    logic [6:0] shin;
    logic [7:0] byte_in, txr, ahi, sr_new;
    logic abyte, is_read, load_pend, sr_got;
    logic [ADDR_W-1:0] ptr;
    logic [PAGE_W-1:0] pidx;
    logic [7:0] pbuf [PAGE];
    logic [PAGE-1:0] pmask;
    logic wip, wel, kind_data, lock_en;
    logic [1:0] bp;
    logic [CNT_W-1:0] wcnt;
    logic [7:0] mem_rd, status;
    logic [ADDR_W-1:0] waddr;
    logic mem_we, locked;

    wire sck_rise  = sck_s & ~sck_q & ~cs_s;
    wire sck_fall  = ~sck_s & sck_q & ~cs_s;
    wire cs_fall   = ~cs_s & cs_q;
    wire cs_rise   = cs_s & ~cs_q;
    wire byte_done = sck_rise && (bcnt == 3'd7);
    assign byte_in = {shin, si_s};

    assign status  = {lock_en, 3'b000, bp, wel, wip};
    assign locked  = ~wp_s & lock_en;

    function automatic logic is_prot(input logic [ADDR_W-1:0] a, input logic [1:0] lvl);
        case (lvl)
            2'b00:   return 1'b0;
            2'b01:   return &a[ADDR_W-1:ADDR_W-2];
            2'b10:   return a[ADDR_W-1];
            default: return 1'b1;
        endcase
    endfunction

    // write engine address and strobe
    assign waddr  = {ptr[ADDR_W-1:PAGE_W], wcnt[PAGE_W-1:0]};
    assign mem_we = wip && kind_data && (wcnt < CNT_W'(PAGE))
                    && pmask[wcnt[PAGE_W-1:0]] && !is_prot(waddr, bp);

    spi_ee_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(waddr),
        .wdata(pbuf[wcnt[PAGE_W-1:0]]), .raddr(ptr), .rdata(mem_rd)
    );

    // next state
    always_comb begin
        nxt = state;
        if (cs_s) begin
            nxt = ST_IDLE;
        end else if (cs_fall) begin
            nxt = ST_OPC;
        end else if (byte_done) begin
            unique case (state)
                ST_OPC: begin
                    if (wip && byte_in != CMD_RSTAT) nxt = ST_SKIP;
                    else if (byte_in == CMD_READ)    nxt = ST_ADDR;
                    else if (byte_in == CMD_WRITE)   nxt = wel ? ST_ADDR : ST_SKIP;
                    else if (byte_in == CMD_RSTAT)   nxt = ST_SROUT;
                    else if (byte_in == CMD_WSTAT)   nxt = wel ? ST_SRIN : ST_SKIP;
                    else                             nxt = ST_SKIP;
                end
                ST_ADDR:  if (abyte) nxt = is_read ? ST_RDATA : ST_WDATA;
                ST_SRIN:  nxt = ST_SKIP;
                ST_IDLE, ST_RDATA, ST_WDATA, ST_SROUT, ST_SKIP: nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0; cs_q <= 1'b0; armed <= 1'b0;
            bcnt <= '0; shin <= '0; txr <= '0; ahi <= '0; sr_new <= '0;
            abyte <= 1'b0; is_read <= 1'b0; load_pend <= 1'b0; sr_got <= 1'b0;
            ptr <= '0; pidx <= '0; pmask <= '0;
            wip <= 1'b0; wel <= 1'b0; kind_data <= 1'b0; lock_en <= 1'b0;
            bp <= '0; wcnt <= '0;
            for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;
            if (cs_fall) begin
                armed  <= 1'b1;
                sr_got <= 1'b0;
            end
            if (cs_s) bcnt <= '0;
            else if (sck_rise) begin
                shin <= {shin[5:0], si_s};
                bcnt <= bcnt + 3'd1;
            end

            if (byte_done) begin
                unique case (state)
                    ST_OPC: begin
                        abyte <= 1'b0;
                        if (byte_in == CMD_RSTAT) load_pend <= 1'b1;
                        else if (!wip) begin
                            if (byte_in == CMD_WEN)   wel <= 1'b1;
                            if (byte_in == CMD_WDIS)  wel <= 1'b0;
                            if (byte_in == CMD_READ)  is_read <= 1'b1;
                            if (byte_in == CMD_WRITE) is_read <= 1'b0;
                        end
                    end
                    ST_ADDR: begin
                        if (!abyte) begin
                            ahi   <= byte_in;
                            abyte <= 1'b1;
                        end else begin
                            ptr   <= ADDR_W'({ahi, byte_in});
                            pidx  <= byte_in[PAGE_W-1:0];
                            if (is_read) load_pend <= 1'b1;
                            else         pmask <= '0;
                        end
                    end
                    ST_RDATA: begin
                        ptr       <= ptr + 1'b1;
                        load_pend <= 1'b1;
                    end
                    ST_WDATA: begin
                        pbuf[pidx]  <= byte_in;
                        pmask[pidx] <= 1'b1;
                        pidx        <= pidx + 1'b1;
                    end
                    ST_SROUT: load_pend <= 1'b1;
                    ST_SRIN: begin
                        sr_new <= byte_in;
                        sr_got <= 1'b1;
                    end
                    ST_IDLE, ST_SKIP: ;
                endcase
            end

            if (sck_fall && (state == ST_RDATA || state == ST_SROUT)) begin
                if (load_pend) begin
                    txr       <= (state == ST_SROUT) ? status : mem_rd;
                    load_pend <= 1'b0;
                end else begin
                    txr <= {txr[6:0], 1'b0};
                end
            end

            if (cs_rise && !wip) begin
                if (|pmask) begin
                    wip <= 1'b1; kind_data <= 1'b1; wcnt <= '0;
                end else if (sr_got && !locked) begin
                    bp <= sr_new[3:2]; lock_en <= sr_new[7];
                    wip <= 1'b1; kind_data <= 1'b0; wcnt <= '0;
                end
            end else if (wip) begin
                wcnt <= wcnt + 1'b1;
                if (wcnt == CNT_W'(WR_CYCLES - 1)) begin
                    wip   <= 1'b0;
                    wel   <= 1'b0;
                    pmask <= '0;
                end
            end
        end
    end

    assign miso    = txr[7];
    assign miso_en = ~cs_s && (state == ST_RDATA || state == ST_SROUT);

    // assertions beside the logic they guard
    p_dormant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> state == ST_IDLE);
    p_wdata_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WDATA |-> wel);
    p_wip_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_rise));
    p_wel_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);
    p_busy_status_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && miso_en) |-> state == ST_SROUT);
    p_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> ($stable(bp) && $stable(lock_en)));
endmodule

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WR = 600;
    localparam int DEPTH = 4096;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso, miso_en;
    int checks = 0, fails = 0;
    bit finished = 1'b0, mode3 = 1'b0;

    logic [7:0] mem_m [DEPTH];
    logic [1:0] bp_m = 2'b00;
    logic wel_m = 1'b0, lock_m = 1'b0;
    logic [7:0] wdat [40];

    spi_eeprom_slave #(.ADDR_W(12), .PAGE_W(5), .WR_CYCLES(WR)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .miso_en(miso_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit prot_f(input int a, input logic [1:0] lvl);
        case (lvl)
            2'b00:   return 1'b0;
            2'b01:   return a >= 3072;
            2'b10:   return a >= 2048;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] stat_f();
        return {lock_m, 3'b000, bp_m, wel_m, 1'b0};
    endfunction

    task automatic sel();
        sck = mode3; tick(2); cs_n = 1'b0; tick(4);
    endtask

    task automatic desel();
        if (!mode3) sck = 1'b0;
        tick(4); cs_n = 1'b1; tick(6);
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r, output logic oe_all, output logic oe_any);
        oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; mosi = b[i]; tick(4);
            r[i] = miso; oe_all &= miso_en; oe_any |= miso_en;
            sck = 1'b1; tick(4);
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r; logic a, y;
        sel(); xbyte(op, r, a, y); desel();
        if (op == 8'h06) wel_m = 1'b1;
        if (op == 8'h04) wel_m = 1'b0;
    endtask

    task automatic rdsr(output logic [7:0] s, output logic oe_op, output logic oe_dat);
        logic [7:0] r; logic a, y;
        sel(); xbyte(8'h05, r, a, oe_op); xbyte(8'h00, s, oe_dat, y); desel();
    endtask

    task automatic chk_stat(input string req, input logic [7:0] exp);
        logic [7:0] s; logic o1, o2;
        rdsr(s, o1, o2);
        check(req, s, exp);
    endtask

    task automatic do_write(input int addr, input int n);
        logic [7:0] r; logic a, y;
        sel(); xbyte(8'h02, r, a, y); xbyte(8'(addr >> 8), r, a, y); xbyte(8'(addr), r, a, y);
        for (int i = 0; i < n; i++) xbyte(wdat[i], r, a, y);
        desel();
        if (wel_m && n > 0) begin
            for (int i = 0; i < n; i++) begin
                int t;
                t = (addr & 32'hFE0) | ((addr + i) & 31);
                if (!prot_f(t, bp_m)) mem_m[t] = wdat[i];
            end
            tick(WR + 20);
            wel_m = 1'b0;
        end
    endtask

    task automatic do_wrsr(input logic [7:0] v);
        logic [7:0] r; logic a, y;
        sel(); xbyte(8'h01, r, a, y); xbyte(v, r, a, y); desel();
        if (wel_m && !(!wp_n && lock_m)) begin
            bp_m = v[3:2]; lock_m = v[7];
            tick(WR + 20);
            wel_m = 1'b0;
        end
    endtask

    task automatic do_read(input string req, input int addr, input int n);
        logic [7:0] r; logic a, y;
        sel(); xbyte(8'h03, r, a, y); xbyte(8'(addr >> 8), r, a, y); xbyte(8'(addr), r, a, y);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r, a, y);
            check(req, r, mem_m[(addr + i) % DEPTH]);
            check({req, " oe"}, a, 1'b1);
        end
        desel();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, r; logic o1, o2;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
        void'($urandom(32'h1badcafe));
        tick(5); rst_n = 1'b1; tick(4);
        check("R2 reset miso_en", miso_en, 1'b0);

        // R1: cs held low since reset, never fell: status read must not answer
        xbyte(8'h05, r, o1, o2); check("R1 dormant opcode oe", o2, 1'b0);
        xbyte(8'h00, r, o1, o2); check("R1 dormant data oe", o2, 1'b0);
        sck = 1'b0; tick(4); cs_n = 1'b1; tick(6);

        // R4 / R2 status read, enable only on the data byte
        rdsr(s, o1, o2);
        check("R4 status after reset", s, 8'h00);
        check("R2 oe low on opcode", o1, 1'b0);
        check("R2 oe high on status data", o2, 1'b1);
        check("R2 oe low when deselected", miso_en, 1'b0);

        // R6 write without enable
        wdat[0] = 8'hAA; do_write(12'h010, 1);
        chk_stat("R6 no cycle without enable", 8'h00);
        do_read("R6 location unchanged", 12'h010, 1);

        // R5 enable / disable
        cmd1(8'h06); chk_stat("R5 enable sets latch", 8'h02);
        cmd1(8'h04); chk_stat("R5 disable clears latch", 8'h00);

        // R7 page wrap, R9 busy, R10 commands ignored while busy
        cmd1(8'h06);
        for (int i = 0; i < 5; i++) wdat[i] = 8'h30 + 8'(i);
        begin
            sel(); xbyte(8'h02, r, o1, o2); xbyte(8'h00, r, o1, o2); xbyte(8'h5E, r, o1, o2);
            for (int i = 0; i < 5; i++) xbyte(wdat[i], r, o1, o2);
            desel();
            for (int i = 0; i < 5; i++) mem_m[12'h040 | ((12'h05E + i) & 31)] = wdat[i];
        end
        chk_stat("R9 busy and latch visible", 8'h03);
        sel(); xbyte(8'h03, r, o1, o2); xbyte(8'h00, r, o1, o2); xbyte(8'h00, r, o1, o2);
        xbyte(8'h00, r, o1, o2); desel();
        check("R10 read ignored while busy", o2, 1'b0);
        cmd1(8'h04); wel_m = 1'b1;   // disable during busy must not clear the latch early
        chk_stat("R10 disable ignored while busy", 8'h03);
        tick(WR + 20); wel_m = 1'b0;
        chk_stat("R9 cycle ended, latch cleared", 8'h00);
        do_read("R7 page wrap tail", 12'h05E, 2);
        do_read("R7 page wrap head", 12'h040, 4);

        // R3 mode 3 read of the same bytes
        mode3 = 1'b1; tick(4);
        do_read("R3 mode3 read", 12'h05C, 6);
        chk_stat("R3 mode3 status", 8'h00);
        mode3 = 1'b0; sck = 1'b0; tick(4);

        // R8 read wrap at array end, upper address bits ignored
        cmd1(8'h06); wdat[0] = 8'h11; wdat[1] = 8'h22; do_write(12'hFFE, 2);
        cmd1(8'h06); wdat[0] = 8'h33; do_write(12'h000, 1);
        do_read("R8 wrap end to start", 12'hFFE, 3);
        begin
            sel(); xbyte(8'h03, r, o1, o2); xbyte(8'hF0, r, o1, o2); xbyte(8'h00, r, o1, o2);
            xbyte(8'h00, r, o1, o2); desel();
            check("R8 upper address bits ignored", r, 8'h33);
        end

        // R13 unknown opcode then enable in same selection
        sel(); xbyte(8'hA5, r, o1, o2); xbyte(8'h06, r, o1, o2); xbyte(8'h00, r, o1, o2); desel();
        check("R13 no output after unknown", o2, 1'b0);
        chk_stat("R13 enable after unknown ignored", 8'h00);

        // R11 protect levels
        for (int lvl = 1; lvl < 4; lvl++) begin
            int pts [6];
            pts = '{12'h000, 12'h7FF, 12'h800, 12'hBFF, 12'hC00, 12'hFFF};
            cmd1(8'h06); do_wrsr(8'(lvl << 2));
            chk_stat("R11 protect level set", stat_f());
            for (int k = 0; k < 6; k++) begin
                cmd1(8'h06); wdat[0] = 8'($urandom); do_write(pts[k], 1);
                wel_m = 1'b0;
                do_read("R11 protected range", pts[k], 1);
            end
        end

        // R12 lock
        cmd1(8'h06); do_wrsr(8'h84);
        chk_stat("R12 lock enable set", 8'h84);
        wp_n = 1'b0; tick(4);
        cmd1(8'h06); do_wrsr(8'h00);
        chk_stat("R12 locked status write", 8'h86);
        wp_n = 1'b1; tick(4);
        do_wrsr(8'h00);
        chk_stat("R12 unlocked status write", 8'h00);

        // random page writes and reads in both modes
        for (int it = 0; it < 12; it++) begin
            int a, n, ra, rn;
            a = int'($urandom_range(0, DEPTH - 1));
            n = int'($urandom_range(1, 36));
            mode3 = $urandom_range(0, 1) == 1; sck = mode3; tick(4);
            for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
            cmd1(8'h06); do_write(a, n);
            ra = (a & 32'hFE0) - 2; if (ra < 0) ra += DEPTH;
            rn = int'($urandom_range(4, 36));
            do_read("R7 random page write", ra, rn);
        end
        mode3 = 1'b0; sck = 1'b0; tick(4);
        chk_stat("R9 idle after random", 8'h00);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule